// File: doc/BRIEF.md
# Segment Descriptor Shadow and Access Check

This block keeps a private copy of the segment descriptor for each of four segment registers. The copy holds the segment's base address, its limit and its access rights. When software loads a segment register, the address logic also presents the descriptor that belongs to the new selector. The block captures that descriptor into the matching shadow entry on the same clock edge. The shadow entries are visible only to the address path.

Every memory reference goes through the block, code fetches included. A reference supplies a segment index, a 16-bit offset, an access kind and a byte count. The block first checks presence, then rights, then the limit. If all checks pass, one cycle later it presents a 24-bit physical address equal to base plus offset. If any check fails, no address comes out. Instead a one-cycle fault strobe is raised, together with the segment index and a cause code.

Top module: `seg_desc_check`

## Requirements
- R1: After reset both output strobes are low and all four entries are not present. An access to any segment before a load faults with cause 1 (not present).
- R2: A load with `ld_valid` high writes base, limit and rights into the entry selected by `ld_seg`. Accesses that start from the next cycle use them. Rights bits are: [3] present, [2] readable, [1] writable, [0] executable.
- R3: A passing access drives `pa_valid` high for exactly the cycle after `acc_valid`, with `pa_addr` = (base + offset) mod 2^24.
- R4: Let the last byte be offset + `acc_size`, where `acc_size` is the byte count minus 1. The access faults with cause 5 (limit) when the last byte is greater than the limit, computed without wrap. A last byte equal to the limit passes.
- R5: A write (`acc_kind` = 01) to a segment whose writable bit is 0 faults with cause 2.
- R6: A fetch (`acc_kind` = 10) from a segment whose executable bit is 0 faults with cause 3. A read (`acc_kind` = 00 or 11) from a segment whose readable bit is 0 faults with cause 4. A fetch does not need the readable bit.
- R7: When several checks fail, the cause reported is the first in this order: not present, then rights, then limit.
- R8: A faulting access raises `flt_valid` for exactly one cycle, the cycle after `acc_valid`. `flt_seg` and `flt_code` are valid during that cycle and `pa_valid` stays low.
- R9: A load and an access to the same segment in the same cycle check the access against the entry as it was before the load.
- R10: A load changes only the entry it selects.
- R11: In a cycle after one with `acc_valid` low, both `pa_valid` and `flt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_seg | input | 2 | Entry to load |
| ld_base | input | 24 | Segment base address |
| ld_limit | input | 16 | Highest valid offset |
| ld_rights | input | 4 | Rights: present, readable, writable, executable |
| acc_valid | input | 1 | Access request strobe |
| acc_seg | input | 2 | Segment of the access |
| acc_off | input | 16 | Offset within the segment |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| acc_size | input | 2 | Bytes accessed minus 1 |
| pa_valid | output | 1 | Physical address strobe |
| pa_addr | output | 24 | Physical address |
| flt_valid | output | 1 | Fault strobe |
| flt_seg | output | 2 | Segment that faulted |
| flt_code | output | 3 | Cause: 1 not present, 2 write, 3 fetch, 4 read, 5 limit |

## Verification
The bench probes the limit edge from both sides. A last byte equal to the limit must pass, and one byte more must fault. An offset near 0xFFFF combined with a multi-byte size must fault rather than wrap back under the limit; a design that truncated the sum to 16 bits would let it through. It sets up descriptors that break several rules at once, so that a wrong priority order shows up as the wrong cause code. It reloads a segment in the same cycle it is accessed, which exposes a design that forwards the new base too early. It also uses a base near the top of the 24-bit space to check that the sum wraps.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NSEG   = 4;
  localparam int SEG_W  = $clog2(NSEG);
  localparam int BASE_W = 24;
  localparam int LIM_W  = 16;
  localparam int RTS_W  = 4;

  localparam int RT_P = 3;
  localparam int RT_R = 2;
  localparam int RT_W = 1;
  localparam int RT_X = 0;

  typedef enum logic [1:0] {
    K_READ  = 2'b00,
    K_WRITE = 2'b01,
    K_FETCH = 2'b10,
    K_READ2 = 2'b11
  } acc_kind_e;

  typedef enum logic [2:0] {
    F_NONE  = 3'd0,
    F_NP    = 3'd1,
    F_WRITE = 3'd2,
    F_EXEC  = 3'd3,
    F_READ  = 3'd4,
    F_LIMIT = 3'd5
  } flt_code_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [RTS_W-1:0]  rights;
  } desc_t;
endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store
  import seg_pkg::*;
#(
  parameter int N = NSEG,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  desc_t         wr_desc,
  input  logic [IW-1:0] rd_idx,
  output desc_t         rd_desc
);
  desc_t        mem [N];
  logic [N-1:0] present_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_desc;
  end

  always_ff @(posedge clk) begin
    if (rst) present_q <= '0;
    else if (wr_en) present_q[wr_idx] <= wr_desc.rights[RT_P];
  end

  always_comb begin
    rd_desc = mem[rd_idx];
    rd_desc.rights[RT_P] = present_q[rd_idx];
  end
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
  import seg_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  desc_t             desc,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        kind,
  input  logic [1:0]        size_m1,
  output logic              ok,
  output logic [2:0]        code,
  output logic [BASE_W-1:0] addr
);
  logic [OFF_W:0] last_byte;
  logic           over;

  always_comb begin
    last_byte = {1'b0, off} + {{(OFF_W-1){1'b0}}, size_m1};
    over      = last_byte > {{(OFF_W+1-LIM_W){1'b0}}, desc.limit};
    code      = F_NONE;
    if (!desc.rights[RT_P])                               code = F_NP;
    else if (kind == K_WRITE && !desc.rights[RT_W])       code = F_WRITE;
    else if (kind == K_FETCH && !desc.rights[RT_X])       code = F_EXEC;
    else if ((kind == K_READ || kind == K_READ2) && !desc.rights[RT_R])
                                                          code = F_READ;
    else if (over)                                        code = F_LIMIT;
    ok   = (code == F_NONE);
    addr = desc.base + BASE_W'(off);
  end
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [BASE_W-1:0] ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  input  logic [RTS_W-1:0]  ld_rights,
  input  logic              acc_valid,
  input  logic [SEG_W-1:0]  acc_seg,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  output logic              pa_valid,
  output logic [BASE_W-1:0] pa_addr,
  output logic              flt_valid,
  output logic [SEG_W-1:0]  flt_seg,
  output logic [2:0]        flt_code
);
  desc_t             cur_desc;
  logic              chk_ok;
  logic [2:0]        chk_code;
  logic [BASE_W-1:0] chk_addr;

  seg_desc_store #(.N(NSEG)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ld_valid),
    .wr_idx  (ld_seg),
    .wr_desc ('{base: ld_base, limit: ld_limit, rights: ld_rights}),
    .rd_idx  (acc_seg),
    .rd_desc (cur_desc)
  );

  seg_prot_check #(.OFF_W(OFF_W)) u_chk (
    .desc    (cur_desc),
    .off     (acc_off),
    .kind    (acc_kind),
    .size_m1 (acc_size),
    .ok      (chk_ok),
    .code    (chk_code),
    .addr    (chk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_valid  <= 1'b0;
      pa_addr   <= '0;
      flt_valid <= 1'b0;
      flt_seg   <= '0;
      flt_code  <= F_NONE;
    end else begin
      pa_valid  <= acc_valid && chk_ok;
      flt_valid <= acc_valid && !chk_ok;
      if (acc_valid && chk_ok) pa_addr <= chk_addr;
      if (acc_valid && !chk_ok) begin
        flt_seg  <= acc_seg;
        flt_code <= chk_code;
      end
    end
  end
endmodule

// File: rtl/seg_desc_check_sva.sv
module seg_desc_check_sva
  import seg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ld_valid,
  input logic [SEG_W-1:0] ld_seg,
  input logic [RTS_W-1:0] ld_rights,
  input logic             acc_valid,
  input logic [SEG_W-1:0] acc_seg,
  input logic             pa_valid,
  input logic             flt_valid,
  input logic [SEG_W-1:0] flt_seg,
  input logic [2:0]       flt_code
);
  logic [NSEG-1:0] shadow_p;

  always_ff @(posedge clk) begin
    if (rst) shadow_p <= '0;
    else if (ld_valid) shadow_p[ld_seg] <= ld_rights[RT_P];
  end

  AST_NOT_PRESENT_FAULT: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !shadow_p[acc_seg] |=> flt_valid && flt_code == F_NP); // R1

  AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (rst)
    !(pa_valid && flt_valid)); // R8

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> pa_valid || flt_valid); // R3

  AST_FAULT_SEG: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> !flt_valid || flt_seg == $past(acc_seg)); // R8

  AST_FAULT_CODE_NZ: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> flt_code != F_NONE && flt_code <= F_LIMIT); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !pa_valid && !flt_valid); // R11
endmodule

bind seg_desc_check seg_desc_check_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .ld_valid  (ld_valid),
  .ld_seg    (ld_seg),
  .ld_rights (ld_rights),
  .acc_valid (acc_valid),
  .acc_seg   (acc_seg),
  .pa_valid  (pa_valid),
  .flt_valid (flt_valid),
  .flt_seg   (flt_seg),
  .flt_code  (flt_code)
);

// File: tb/seg_desc_check_tb.sv
module seg_desc_check_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [23:0] ld_base = '0;
  logic [15:0] ld_limit = '0;
  logic [3:0]  ld_rights = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_seg = '0;
  logic [15:0] acc_off = '0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  acc_size = '0;
  logic        pa_valid;
  logic [23:0] pa_addr;
  logic        flt_valid;
  logic [1:0]  flt_seg;
  logic [2:0]  flt_code;

  always #2.5 clk = ~clk;

  seg_desc_check u_dut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_base(ld_base),
    .ld_limit(ld_limit), .ld_rights(ld_rights),
    .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
    .acc_kind(acc_kind), .acc_size(acc_size),
    .pa_valid(pa_valid), .pa_addr(pa_addr),
    .flt_valid(flt_valid), .flt_seg(flt_seg), .flt_code(flt_code)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [23:0] m_base [4];
  logic [15:0] m_lim  [4];
  logic [3:0]  m_rts  [4];

  typedef struct packed {
    logic        is_flt;
    logic [23:0] addr;
    logic [1:0]  seg;
    logic [2:0]  code;
    int          due;
  } exp_t;
  exp_t  exp_q [$];
  string tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit cond, string tag, string what, int act, int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: compare one result per due cycle, otherwise expect idle outputs
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(flt_valid == e.is_flt, t, "flt_valid", int'(flt_valid), int'(e.is_flt));
          check(pa_valid == !e.is_flt, t, "pa_valid", int'(pa_valid), int'(!e.is_flt));
          if (e.is_flt) begin
            check(flt_code == e.code, t, "flt_code", int'(flt_code), int'(e.code));
            check(flt_seg == e.seg, t, "flt_seg", int'(flt_seg), int'(e.seg));
          end else begin
            check(pa_addr == e.addr, t, "pa_addr", int'(pa_addr), int'(e.addr));
          end
        end else begin
          check(!pa_valid && !flt_valid, "R11", "idle strobes",
                int'({pa_valid, flt_valid}), 0);
        end
      end
    end
  end

  function automatic exp_t model(logic [1:0] s, logic [15:0] off,
                                 logic [1:0] k, logic [1:0] sz);
    exp_t e;
    logic [16:0] last;
    e = '0;
    e.seg = s;
    last = {1'b0, off} + {15'd0, sz};
    if (!m_rts[s][3])                          e.code = 3'd1;
    else if (k == 2'b01 && !m_rts[s][1])       e.code = 3'd2;
    else if (k == 2'b10 && !m_rts[s][0])       e.code = 3'd3;
    else if (k[0] == k[1] && !m_rts[s][2])     e.code = 3'd4;
    else if (last > {1'b0, m_lim[s]})          e.code = 3'd5;
    e.is_flt = (e.code != 3'd0);
    e.addr = m_base[s] + {8'd0, off};
    e.due = cyc + 1;
    return e;
  endfunction

  // apply at a negedge; value stays for one cycle
  task automatic access(logic [1:0] s, logic [15:0] off, logic [1:0] k,
                        logic [1:0] sz, string tag);
    exp_q.push_back(model(s, off, k, sz));
    tag_q.push_back(tag);
    acc_valid = 1'b1; acc_seg = s; acc_off = off; acc_kind = k; acc_size = sz;
  endtask

  task automatic load(logic [1:0] s, logic [23:0] b, logic [15:0] l, logic [3:0] r);
    ld_valid = 1'b1; ld_seg = s; ld_base = b; ld_limit = l; ld_rights = r;
  endtask

  task automatic commit_load();
    if (ld_valid) begin
      m_base[ld_seg] = ld_base; m_lim[ld_seg] = ld_limit; m_rts[ld_seg] = ld_rights;
    end
  endtask

  task automatic step();
    @(posedge clk);
    commit_load();
    @(negedge clk);
    ld_valid = 1'b0;
    acc_valid = 1'b0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3", "results outstanding", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_rts[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!pa_valid && !flt_valid, "R1", "reset strobes", int'({pa_valid, flt_valid}), 0);

    // R1: nothing loaded yet, every segment not present
    for (int s = 0; s < 4; s++) begin
      access(2'(s), 16'h0010, 2'b00, 2'd0, "R1");
      step();
    end

    // R2 R3: load seg0 readable/writable, then read
    load(2'd0, 24'h010000, 16'h0FFF, 4'b1110); step();
    access(2'd0, 16'h0010, 2'b00, 2'd0, "R2"); step();
    access(2'd0, 16'h0123, 2'b01, 2'd1, "R3"); step();

    // R4: limit edges, back-to-back
    access(2'd0, 16'h0FFF, 2'b00, 2'd0, "R4"); step();
    access(2'd0, 16'h0FFE, 2'b00, 2'd1, "R4"); step();
    access(2'd0, 16'h0FFF, 2'b00, 2'd1, "R4"); step();
    load(2'd3, 24'h200000, 16'hFFFF, 4'b1111); step();
    access(2'd3, 16'hFFFF, 2'b00, 2'd3, "R4"); step();
    access(2'd3, 16'hFFFC, 2'b00, 2'd3, "R4"); step();

    // R5 R6: rights violations
    load(2'd1, 24'h030000, 16'h00FF, 4'b1101); step();
    access(2'd1, 16'h0004, 2'b01, 2'd0, "R5"); step();
    access(2'd1, 16'h0004, 2'b10, 2'd0, "R6"); step();
    access(2'd0, 16'h0004, 2'b10, 2'd0, "R6"); step();
    load(2'd2, 24'h040000, 16'h00FF, 4'b1011); step();
    access(2'd2, 16'h0008, 2'b00, 2'd0, "R6"); step();
    access(2'd2, 16'h0008, 2'b11, 2'd0, "R6"); step();
    access(2'd2, 16'h0008, 2'b10, 2'd0, "R6"); step();

    // R7: multiple violations
    access(2'd1, 16'h0200, 2'b01, 2'd0, "R7"); step();
    load(2'd3, 24'h200000, 16'h0000, 4'b0110); step();
    access(2'd3, 16'h0500, 2'b10, 2'd0, "R7"); step();
    access(2'd2, 16'h0300, 2'b00, 2'd0, "R7"); step();

    // R3: 24-bit wrap of base plus offset
    load(2'd3, 24'hFFFF00, 16'hFFFF, 4'b1111); step();
    access(2'd3, 16'h0200, 2'b10, 2'd0, "R3"); step();

    // R8: fault then pass back-to-back, then idle
    access(2'd1, 16'h0001, 2'b01, 2'd0, "R8"); step();
    access(2'd1, 16'h0001, 2'b00, 2'd0, "R8"); step();
    step();

    // R9: reload seg0 while it is being accessed
    load(2'd0, 24'h0A0000, 16'h0FFF, 4'b0000);
    access(2'd0, 16'h0020, 2'b00, 2'd0, "R9"); step();
    access(2'd0, 16'h0020, 2'b00, 2'd0, "R9"); step();
    load(2'd0, 24'h0B0000, 16'h0FFF, 4'b1100);
    access(2'd0, 16'h0020, 2'b00, 2'd0, "R9"); step();
    access(2'd0, 16'h0020, 2'b00, 2'd0, "R9"); step();

    // R10: reloading seg2 leaves seg1 and seg0 alone
    load(2'd2, 24'h777777, 16'h0001, 4'b0000); step();
    access(2'd1, 16'h0010, 2'b00, 2'd0, "R10"); step();
    access(2'd0, 16'h0040, 2'b00, 2'd0, "R10"); step();

    repeat (4) step();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule